// File: doc/BRIEF.md
# Register Writeback Collision Detector

This block watches the issue stream of an in-order VLIW pipeline. It reports any cycle in which two issued instructions would write their results into the same architectural register. Each cycle it receives a set of issue slots. Each slot carries a valid bit, a kill bit, a latency class, a destination side and a destination register number. The kill bit marks a slot that was squashed by a taken branch.

The check is made on the cycle in which a result lands, not on the slot in which it was issued. A single-cycle operation lands in its issue cycle. A multiply lands one cycle later. To support this, each side keeps a one-entry pending record holding the destination of the multiply issued in the previous cycle. In every cycle the detector compares the set of writes landing in that cycle: the pending multiply writes plus the live single-cycle writes from the current slots. It raises a flag together with the register concerned.

The issuing logic must present at most one live multiply per side per cycle, since each side has one multiplier. A multiply's pending record belongs to the side named in its destination field.

Top module: `wb_collision_det`

## Requirements
- R1: Two live single-cycle slots (latency class bit 0) with the same destination identity raise `wb_clash` combinationally in that same cycle, before the next clock edge.
- R2: Register identity is the pair {side, register number}, reported on `wb_clash_id` with the side in the upper bits (identity = side * 2^REG_W + register). Writes that differ in side or in register number never clash.
- R3: A multiply (latency class bit 1) lands one cycle after issue. A multiply issued in cycle t and a single-cycle operation issued in cycle t+1 with the same identity clash in cycle t+1 and not in cycle t.
- R4: A multiply and a single-cycle operation with the same identity issued in the same cycle do not clash. Two multiplies with the same identity issued in consecutive cycles do not clash.
- R5: A slot with valid low or kill high is not a writer, neither in its issue cycle nor, for a multiply, in the following cycle.
- R6: Kill bits raised in the cycle after a multiply was issued do not remove that multiply's pending write.
- R7: `wb_clash` is high only in the cycle in which the colliding writes land. `wb_clash_id` is zero whenever `wb_clash` is low.
- R8: When several distinct identities collide in one cycle, `wb_clash_id` reports the numerically lowest of them.
- R9: With the synchronous reset high, both outputs are low. A clock edge with reset high clears all pending writes, so a multiply issued in a reset cycle is never counted.
- R10: The pairwise-comparator and the register-bitmap detection variants, chosen by parameter, produce identical outputs for every input sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| iss_vld | input | NSLOT | Slot holds an issued instruction |
| iss_kill | input | NSLOT | Slot squashed by a taken branch |
| iss_mul | input | NSLOT | Latency class: 1 = multiply (lands next cycle), 0 = single-cycle |
| iss_side | input | NSLOT*log2(NSIDE) | Destination side per slot |
| iss_reg | input | NSLOT*REG_W | Destination register number per slot |
| wb_clash | output | 1 | Two or more writes land on one register this cycle |
| wb_clash_id | output | log2(NSIDE)+REG_W | {side, register} of the lowest colliding identity, else zero |

## Verification
The two functions that meet in one cycle are the drain of a pending multiply write and the landing of fresh single-cycle writes. Often a kill on neighbouring slots arrives in that same cycle. The bench provokes this by issuing a multiply and then, on the next cycle, single-cycle operations to every possible identity, some of them killed. It judges the flag and identity in that second cycle against a bench model that counts writes per identity from the slot fields. Exhaustive pair sweeps over a small configuration and a long pseudo-random stream then compare both detection variants against that model.

// File: rtl/wbc_pkg.sv
package wbc_pkg;

   // Detection structure chosen at elaboration.
   typedef enum int unsigned {
      DET_PAIRWISE = 0,
      DET_BITMAP   = 1
   } det_mode_e;

   // Latency class encoding on the issue slots.
   localparam logic LAT_SINGLE = 1'b0;
   localparam logic LAT_MULT   = 1'b1;

endpackage

// File: rtl/wbc_pend_slot.sv
// One-entry pending multiply record for a single side.
module wbc_pend_slot #(
   parameter int NSLOT   = 8,
   parameter int SIDE_W  = 1,
   parameter int REG_W   = 5,
   parameter int SIDE_ID = 0
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic [NSLOT-1:0]        live,
   input  logic [NSLOT-1:0]        mul,
   input  logic [NSLOT*SIDE_W-1:0] side,
   input  logic [NSLOT*REG_W-1:0]  rg,
   output logic                    pend_vld,
   output logic [REG_W-1:0]        pend_reg
);

   logic             take;
   logic [REG_W-1:0] take_reg;

   // Lowest slot wins; the issue contract allows only one live multiply per side.
   always_comb begin
      take     = 1'b0;
      take_reg = '0;
      for (int s = NSLOT - 1; s >= 0; s--) begin
         if (live[s] && (mul[s] == wbc_pkg::LAT_MULT) &&
             (side[s*SIDE_W +: SIDE_W] == SIDE_W'(SIDE_ID))) begin
            take     = 1'b1;
            take_reg = rg[s*REG_W +: REG_W];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         pend_vld <= 1'b0;
         pend_reg <= '0;
      end else begin
         pend_vld <= take;
         pend_reg <= take_reg;
      end
   end

endmodule

// File: rtl/wbc_detect.sv
// Finds identities written more than once among the landing writes.
module wbc_detect import wbc_pkg::*; #(
   parameter int        NW   = 10,
   parameter int        ID_W = 6,
   parameter det_mode_e MODE = DET_PAIRWISE
) (
   input  logic [NW-1:0]      live,
   input  logic [NW*ID_W-1:0] id,
   output logic               hit,
   output logic [ID_W-1:0]    hit_id
);

   if (MODE == DET_PAIRWISE) begin : g_pair
      logic [NW-1:0] dup;
      logic          found;

      always_comb begin
         for (int i = 0; i < NW; i++) begin
            dup[i] = 1'b0;
            for (int j = 0; j < NW; j++) begin
               if ((j != i) && live[i] && live[j] &&
                   (id[i*ID_W +: ID_W] == id[j*ID_W +: ID_W]))
                  dup[i] = 1'b1;
            end
         end
         found  = 1'b0;
         hit_id = '0;
         for (int i = 0; i < NW; i++) begin
            if (dup[i] && (!found || (id[i*ID_W +: ID_W] < hit_id))) begin
               hit_id = id[i*ID_W +: ID_W];
               found  = 1'b1;
            end
         end
      end

      assign hit = |dup;
   end else begin : g_bitmap
      localparam int NID = 1 << ID_W;
      logic [NID-1:0] multi;
      logic [1:0]     cnt;

      always_comb begin
         for (int r = 0; r < NID; r++) begin
            cnt = 2'd0;
            for (int e = 0; e < NW; e++) begin
               if (live[e] && (id[e*ID_W +: ID_W] == ID_W'(r)) && (cnt != 2'd2))
                  cnt = cnt + 2'd1;
            end
            multi[r] = (cnt == 2'd2);
         end
         hit_id = '0;
         for (int r = NID - 1; r >= 0; r--) begin
            if (multi[r]) hit_id = ID_W'(r);
         end
      end

      assign hit = |multi;
   end

endmodule

// File: rtl/wb_collision_det.sv
module wb_collision_det import wbc_pkg::*; #(
   parameter int        NSLOT    = 8,
   parameter int        NSIDE    = 2,
   parameter int        REG_W    = 5,
   parameter det_mode_e DET_MODE = DET_PAIRWISE
) (
   input  logic                             clk,
   input  logic                             rst,
   input  logic [NSLOT-1:0]                 iss_vld,
   input  logic [NSLOT-1:0]                 iss_kill,
   input  logic [NSLOT-1:0]                 iss_mul,
   input  logic [NSLOT*$clog2(NSIDE)-1:0]   iss_side,
   input  logic [NSLOT*REG_W-1:0]           iss_reg,
   output logic                             wb_clash,
   output logic [$clog2(NSIDE)+REG_W-1:0]   wb_clash_id
);

   localparam int SIDE_W = $clog2(NSIDE);
   localparam int ID_W   = SIDE_W + REG_W;
   localparam int NW     = NSIDE + NSLOT;

   // Elaboration-time parameter checks.
   if (NSLOT < 2) begin : g_bad_slots
      $error("wb_collision_det: NSLOT must be at least 2");
   end
   if ((NSIDE < 2) || ((1 << SIDE_W) != NSIDE)) begin : g_bad_sides
      $error("wb_collision_det: NSIDE must be a power of two, at least 2");
   end
   if (REG_W < 1) begin : g_bad_reg
      $error("wb_collision_det: REG_W must be positive");
   end
   if ((DET_MODE == DET_BITMAP) && (ID_W > 10)) begin : g_bad_bitmap
      $error("wb_collision_det: bitmap detection limited to 10 identity bits");
   end

   logic [NSLOT-1:0]       live;
   logic [NSIDE-1:0]       pend_vld;
   logic [NSIDE*REG_W-1:0] pend_reg;
   logic [NW-1:0]          ent_live;
   logic [NW*ID_W-1:0]     ent_id;
   logic                   det_hit;
   logic [ID_W-1:0]        det_id;

   assign live = iss_vld & ~iss_kill;

   // Pending multiply records, one per side; entries 0..NSIDE-1 of the write set.
   for (genvar sd = 0; sd < NSIDE; sd++) begin : g_side
      wbc_pend_slot #(
         .NSLOT   (NSLOT),
         .SIDE_W  (SIDE_W),
         .REG_W   (REG_W),
         .SIDE_ID (sd)
      ) u_pend (
         .clk      (clk),
         .rst      (rst),
         .live     (live),
         .mul      (iss_mul),
         .side     (iss_side),
         .rg       (iss_reg),
         .pend_vld (pend_vld[sd]),
         .pend_reg (pend_reg[sd*REG_W +: REG_W])
      );
      assign ent_live[sd]               = pend_vld[sd];
      assign ent_id[sd*ID_W +: ID_W]    = {SIDE_W'(sd), pend_reg[sd*REG_W +: REG_W]};
   end

   // Single-cycle writes landing now; entries NSIDE..NW-1.
   for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      assign ent_live[NSIDE+s] = live[s] & (iss_mul[s] == LAT_SINGLE);
      assign ent_id[(NSIDE+s)*ID_W +: ID_W] =
         {iss_side[s*SIDE_W +: SIDE_W], iss_reg[s*REG_W +: REG_W]};
   end

   wbc_detect #(
      .NW   (NW),
      .ID_W (ID_W),
      .MODE (DET_MODE)
   ) u_detect (
      .live   (ent_live),
      .id     (ent_id),
      .hit    (det_hit),
      .hit_id (det_id)
   );

   assign wb_clash    = det_hit & ~rst;
   assign wb_clash_id = wb_clash ? det_id : '0;

endmodule

// File: rtl/wbc_chk.sv
// Property checker, attached to the top module by bind below.
module wbc_chk #(
   parameter int NSLOT = 8,
   parameter int NSIDE = 2,
   parameter int REG_W = 5
) (
   input logic                           clk,
   input logic                           rst,
   input logic [NSLOT-1:0]               iss_vld,
   input logic [NSLOT-1:0]               iss_kill,
   input logic [NSLOT-1:0]               iss_mul,
   input logic [NSLOT*$clog2(NSIDE)-1:0] iss_side,
   input logic [NSLOT*REG_W-1:0]         iss_reg,
   input logic                           wb_clash,
   input logic [$clog2(NSIDE)+REG_W-1:0] wb_clash_id,
   input logic [NSIDE-1:0]               pend_vld,
   input logic [NSIDE*REG_W-1:0]         pend_reg
);

   localparam int SW = $clog2(NSIDE);

   logic [NSIDE-1:0] mul_issue;
   logic             pend_meets_single;

   always_comb begin
      mul_issue         = '0;
      pend_meets_single = 1'b0;
      for (int s = 0; s < NSLOT; s++) begin
         for (int sd = 0; sd < NSIDE; sd++) begin
            if (iss_vld[s] && !iss_kill[s] && (iss_side[s*SW +: SW] == SW'(sd))) begin
               if (iss_mul[s])
                  mul_issue[sd] = 1'b1;
               else if (pend_vld[sd] && (iss_reg[s*REG_W +: REG_W] == pend_reg[sd*REG_W +: REG_W]))
                  pend_meets_single = 1'b1;
            end
         end
      end
   end

   for (genvar sd = 0; sd < NSIDE; sd++) begin : g_side_chk
      // R3: a live multiply becomes a pending write on the next cycle
      assert_pend_fill_R3: assert property (@(posedge clk) disable iff (rst)
         mul_issue[sd] |=> pend_vld[sd]);
      // R5: a pending write only comes from a live multiply one cycle earlier
      assert_pend_src_R5: assert property (@(posedge clk) disable iff (rst)
         pend_vld[sd] |-> $past(mul_issue[sd]));
   end

   assert_pend_single_R3: assert property (@(posedge clk) disable iff (rst)
      pend_meets_single |-> wb_clash);

   assert_no_writer_R5: assert property (@(posedge clk) disable iff (rst)
      ((pend_vld == '0) && ((iss_vld & ~iss_kill) == '0)) |-> !wb_clash);

   assert_id_idle_R7: assert property (@(posedge clk) disable iff (rst)
      !wb_clash |-> (wb_clash_id == '0));

   assert_quiet_in_reset_R9: assert property (@(posedge clk)
      rst |-> !wb_clash);

   assert_reset_empty_R9: assert property (@(posedge clk)
      rst |=> (pend_vld == '0));

endmodule

bind wb_collision_det wbc_chk #(
   .NSLOT (NSLOT),
   .NSIDE (NSIDE),
   .REG_W (REG_W)
) u_chk (
   .clk         (clk),
   .rst         (rst),
   .iss_vld     (iss_vld),
   .iss_kill    (iss_kill),
   .iss_mul     (iss_mul),
   .iss_side    (iss_side),
   .iss_reg     (iss_reg),
   .wb_clash    (wb_clash),
   .wb_clash_id (wb_clash_id),
   .pend_vld    (pend_vld),
   .pend_reg    (pend_reg)
);

// File: tb/wb_collision_det_tb.sv
module wb_collision_det_tb;

   localparam int NS  = 4;
   localparam int RW  = 2;
   localparam int IDW = 3;
   localparam int NID = 8;

   logic            clk = 1'b0;
   logic            rst = 1'b1;
   logic [NS-1:0]   vld = '0;
   logic [NS-1:0]   kill = '0;
   logic [NS-1:0]   mul = '0;
   logic [NS-1:0]   side = '0;
   logic [NS*RW-1:0] rg = '0;
   logic            clash_p, clash_b;
   logic [IDW-1:0]  id_p, id_b;

   int errors = 0;
   int checks = 0;
   bit mp_v [2];
   int mp_r [2];
   logic [31:0] lf = 32'hACE1_2468;

   always #10 clk = ~clk;

   wb_collision_det #(.NSLOT(NS), .NSIDE(2), .REG_W(RW),
                      .DET_MODE(wbc_pkg::DET_PAIRWISE)) u_dut (
      .clk(clk), .rst(rst), .iss_vld(vld), .iss_kill(kill), .iss_mul(mul),
      .iss_side(side), .iss_reg(rg), .wb_clash(clash_p), .wb_clash_id(id_p));

   wb_collision_det #(.NSLOT(NS), .NSIDE(2), .REG_W(RW),
                      .DET_MODE(wbc_pkg::DET_BITMAP)) u_dut_bm (
      .clk(clk), .rst(rst), .iss_vld(vld), .iss_kill(kill), .iss_mul(mul),
      .iss_side(side), .iss_reg(rg), .wb_clash(clash_b), .wb_clash_id(id_b));

   task automatic clear_slots();
      vld = '0; kill = '0; mul = '0; side = '0; rg = '0;
   endtask

   // identity = side*4 + reg
   task automatic put(int s, bit k, bit m, int ident);
      vld[s]  = 1'b1;
      kill[s] = k;
      mul[s]  = m;
      side[s] = ident[2];
      rg[s*RW +: RW] = ident[1:0];
   endtask

   task automatic chk(string tag, bit ef, int eid);
      checks++;
      if (clash_p !== ef || int'(id_p) != eid) begin
         errors++;
         $display("FAIL %s pairwise: clash=%0b id=%0d expected clash=%0b id=%0d",
                  tag, clash_p, id_p, ef, eid);
      end
      checks++;
      if (clash_b !== ef || int'(id_b) != eid) begin
         errors++;
         $display("FAIL %s R10 bitmap: clash=%0b id=%0d expected clash=%0b id=%0d",
                  tag, clash_b, id_b, ef, eid);
      end
   endtask

   // Count landing writes per identity from stimulus and bench pending model.
   task automatic model(output bit ef, output int eid);
      int cnt [NID];
      for (int r = 0; r < NID; r++) cnt[r] = 0;
      for (int sd = 0; sd < 2; sd++) if (mp_v[sd]) cnt[sd*4 + mp_r[sd]]++;
      for (int s = 0; s < NS; s++)
         if (vld[s] && !kill[s] && !mul[s]) cnt[int'(side[s])*4 + int'(rg[s*RW +: RW])]++;
      ef = 1'b0; eid = 0;
      for (int r = NID - 1; r >= 0; r--) if (cnt[r] >= 2) begin ef = 1'b1; eid = r; end
      if (rst) begin ef = 1'b0; eid = 0; end
   endtask

   task automatic tick();
      @(posedge clk);
      for (int sd = 0; sd < 2; sd++) begin
         mp_v[sd] = 1'b0; mp_r[sd] = 0;
         if (!rst)
            for (int s = NS - 1; s >= 0; s--)
               if (vld[s] && !kill[s] && mul[s] && int'(side[s]) == sd) begin
                  mp_v[sd] = 1'b1; mp_r[sd] = int'(rg[s*RW +: RW]);
               end
      end
      @(negedge clk);
   endtask

   function automatic logic [31:0] nx(logic [31:0] v);
      logic [31:0] t = v;
      t = t ^ (t << 13);
      t = t ^ (t >> 17);
      t = t ^ (t << 5);
      return t;
   endfunction

   initial begin
      #(20 * 200000);
      errors++; checks++;
      $display("FAIL watchdog all-requirements: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      bit ef; int eid;
      mp_v[0] = 0; mp_v[1] = 0; mp_r[0] = 0; mp_r[1] = 0;
      @(negedge clk);
      // R9: reset hides a collision and forgets a multiply
      clear_slots(); put(0, 0, 0, 2); put(1, 0, 0, 2); put(2, 0, 1, 7);
      #2 chk("R9 outputs low in reset", 1'b0, 0);
      tick();
      rst = 1'b0;
      clear_slots(); put(0, 0, 0, 7);
      #2 chk("R9 multiply from reset cycle dropped", 1'b0, 0);
      tick();
      // R1
      clear_slots(); put(0, 0, 0, 2); put(1, 0, 0, 2);
      #2 chk("R1 two singles same register", 1'b1, 2);
      tick();
      clear_slots();
      #2 chk("R7 flag drops after write cycle", 1'b0, 0);
      tick();
      // R2
      clear_slots(); put(0, 0, 0, 2); put(1, 0, 0, 6); put(2, 0, 0, 1);
      #2 chk("R2 differing side or register", 1'b0, 0);
      tick();
      // R3
      clear_slots(); put(0, 0, 1, 7);
      #2 chk("R3 no clash in multiply issue cycle", 1'b0, 0);
      tick();
      clear_slots(); put(1, 0, 0, 7);
      #2 chk("R3 multiply then single next cycle", 1'b1, 7);
      tick();
      clear_slots();
      #2 chk("R7 idle after clash", 1'b0, 0);
      tick();
      // R4
      clear_slots(); put(0, 0, 1, 1); put(1, 0, 0, 1);
      #2 chk("R4 multiply and single same cycle", 1'b0, 0);
      tick();
      clear_slots();
      #2 chk("R4 lone multiply write lands", 1'b0, 0);
      tick();
      clear_slots(); put(0, 0, 1, 5);
      #2 chk("R4 first multiply", 1'b0, 0);
      tick();
      clear_slots(); put(2, 0, 1, 5);
      #2 chk("R4 second multiply same register", 1'b0, 0);
      tick();
      clear_slots();
      #2 chk("R4 second multiply lands alone", 1'b0, 0);
      tick();
      // R5
      clear_slots(); put(0, 0, 0, 3); put(1, 1, 0, 3); put(2, 0, 0, 3); vld[2] = 1'b0;
      #2 chk("R5 killed and invalid singles", 1'b0, 0);
      tick();
      clear_slots(); put(0, 1, 1, 4);
      #2 chk("R5 killed multiply", 1'b0, 0);
      tick();
      clear_slots(); put(1, 0, 0, 4);
      #2 chk("R5 killed multiply leaves no pending", 1'b0, 0);
      tick();
      // R6
      clear_slots(); put(3, 0, 1, 2);
      #2 chk("R6 multiply issue", 1'b0, 0);
      tick();
      clear_slots(); put(0, 0, 0, 2); put(1, 1, 0, 5); put(2, 1, 1, 2);
      #2 chk("R6 kills after multiply keep pending", 1'b1, 2);
      tick();
      // R8
      clear_slots(); put(0, 0, 0, 6); put(1, 0, 0, 6); put(2, 0, 0, 1); put(3, 0, 0, 1);
      #2 chk("R8 lowest of two identities", 1'b1, 1);
      tick();
      clear_slots(); put(0, 0, 1, 0);
      #2 chk("R8 setup multiply", 1'b0, 0);
      tick();
      clear_slots(); put(1, 0, 0, 0); put(2, 0, 0, 7); put(3, 0, 0, 7);
      #2 chk("R8 pending identity is lowest", 1'b1, 0);
      tick();

      // Exhaustive single pairs over all identities (R1, R2)
      for (int a = 0; a < NID; a++) begin
         for (int b = 0; b < NID; b++) begin
            clear_slots(); put(0, 0, 0, a); put(3, 0, 0, b);
            #2 chk((a == b) ? "R1 pair sweep" : "R2 pair sweep", a == b, (a == b) ? a : 0);
            tick();
         end
      end
      // Exhaustive multiply-then-single over all identities (R3, R6)
      for (int a = 0; a < NID; a++) begin
         for (int b = 0; b < NID; b++) begin
            clear_slots(); put(1, 0, 1, a);
            #2 chk("R3 sweep issue cycle", 1'b0, 0);
            tick();
            clear_slots(); put(2, 0, 0, b); put(0, 1, 0, a);
            #2 chk("R6 sweep landing cycle", a == b, (a == b) ? a : 0);
            tick();
         end
      end

      // Pseudo-random stream against the bench model (R10 and all)
      for (int n = 0; n < 4000; n++) begin
         bit seen [2];
         seen[0] = 0; seen[1] = 0;
         lf = nx(lf);
         rst = (lf[5:0] == 6'd0);
         clear_slots();
         for (int s = 0; s < NS; s++) begin
            lf = nx(lf);
            vld[s]  = lf[0] | lf[1];
            kill[s] = lf[2] & lf[3];
            mul[s]  = lf[4] & lf[5];
            side[s] = lf[6];
            rg[s*RW +: RW] = lf[8:7];
            if (vld[s] && !kill[s] && mul[s]) begin
               if (seen[int'(side[s])]) mul[s] = 1'b0;
               else seen[int'(side[s])] = 1'b1;
            end
         end
         model(ef, eid);
         #2 chk("R10 random stream", ef, eid);
         tick();
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule